// File: doc/BRIEF.md
# Host Command and Interrupt Controller

This block sits between a host register bus and the rest of a network adapter. The host writes 16-bit command words to a single command port. The top five bits of each word choose an operation and the low eleven bits carry its operand. Reading the same port returns a 16-bit status word. That word holds the selected register window, a busy flag for slow commands, and eight interrupt cause bits.

Hardware event pulses set the cause bits, and a request command can set one of them too. They stay set until the host clears them with an acknowledge command, whose operand is a bit mask of causes to clear. A mask register chooses which causes can drive the interrupt line. A summary latch bit records that an enabled cause was raised. The block also holds the receiver on/off state and a 4-bit receive filter.

A global reset command returns all of this state to its power-up values. The busy flag then stays high for a set number of cycles, and commands written during that time are dropped.

Top module: `host_cmd_ctrl`

## Requirements
- R1: A command is a write to address CMD_ADDR (default 0xE). The opcode is wdata[15:11] and the operand is wdata[10:0]. Operand bits that an opcode does not use have no effect, and writes to any other address have no effect.
- R2: Opcode 0x01 loads the window number from operand bits [2:0]. The window appears on win_sel and in status bits [15:13]. No other command changes it except global reset.
- R3: Opcode 0x0D (acknowledge) clears status bit i for each operand bit i set (i = 0..7) and leaves the other cause bits unchanged.
- R4: Opcode 0x0C sets the requested cause, status bit 6. Its operand is ignored.
- R5: A pulse on cause_evt[j] sets status bit j+1. Opcode 0x0E loads the interrupt mask from operand bits [7:1]. Status bit 0 (latch) is set when a cause is raised while its mask bit is set. irq equals the OR of (status[7:1] AND mask) OR'd with status bit 0.
- R6: Opcode 0x00 (global reset) clears the window, all cause bits, the mask, the filter and the receiver enable. It then holds status bit 12 high for RESET_CYCLES cycles.
- R7: While status bit 12 is high, every command write is ignored.
- R8: If a cause event and an acknowledge of the same bit arrive in the same cycle, the bit stays set.
- R9: Opcode 0x04 turns rx_enable on and opcode 0x03 turns it off. It is off after reset.
- R10: Opcode 0x10 loads rx_filter from operand bits [3:0]. The bit meanings are: bit 0 own address, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous.
- R11: rdata shows the status word only while rd_en is high and addr equals CMD_ADDR. Otherwise it is zero. Status bits [11:8] always read zero.
- R12: After rst_n, the status word, irq, win_sel, rx_filter and rx_enable are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data (command word) |
| rdata | output | 16 | Read data (status word at the command port) |
| cause_evt | input | 7 | One-cycle event pulses; bit j sets status bit j+1 |
| irq | output | 1 | Interrupt request |
| win_sel | output | 3 | Currently selected register window |
| rx_enable | output | 1 | Receiver enabled |
| rx_filter | output | 4 | Receive filter bits |

## Verification
The assertions check the following on every cycle:
- The window does not move without a select or reset command.
- A raised latch always drives irq.
- A full acknowledge clears every cause.
- A request command sets bit 6.
- A reset command raises busy and clears state.
- Busy blocks every write.
- A cause event always survives into the next cycle.

Some behaviours can only be shown by the bench's scenarios:
- Exact mask filtering of irq.
- That operand bits are ignored per opcode.
- Read gating by address and strobe.
- The exact length of the busy window.
- The filter and receiver-enable values.

// File: rtl/hcc_pkg.sv
package hcc_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned OPC_W   = 5;
  localparam int unsigned WIN_W   = 3;
  localparam int unsigned CAUSE_N = 7;
  localparam int unsigned FILT_W  = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_GLOBAL_RESET = 5'h00,
    OP_WIN_SEL      = 5'h01,
    OP_RX_OFF       = 5'h03,
    OP_RX_ON        = 5'h04,
    OP_REQ_INT      = 5'h0C,
    OP_ACK_INT      = 5'h0D,
    OP_SET_MASK     = 5'h0E,
    OP_SET_FILTER   = 5'h10
  } hcc_op_e;

  typedef struct packed {
    logic                glb_rst;
    logic                win_sel;
    logic                rx_off;
    logic                rx_on;
    logic                req_int;
    logic                ack_int;
    logic                set_mask;
    logic                set_filt;
    logic [CAUSE_N:0]    arg;
  } hcc_cmd_t;
endpackage

// File: rtl/hcc_cmd_decode.sv
module hcc_cmd_decode
  import hcc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 4'hE
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  output hcc_cmd_t          cmd
);
  localparam int unsigned ARG_TOP = WORD_W - OPC_W - 1;

  logic    accept;
  hcc_op_e opc;
  logic    unused_arg_hi;

  assign accept        = wr_en && (addr == CMD_ADDR) && !busy;
  assign opc           = hcc_op_e'(wdata[WORD_W-1 -: OPC_W]);
  assign unused_arg_hi = ^wdata[ARG_TOP:CAUSE_N+1];

  always_comb begin
    cmd     = '0;
    cmd.arg = wdata[CAUSE_N:0];
    if (accept) begin
      unique case (opc)
        OP_GLOBAL_RESET: cmd.glb_rst  = 1'b1;
        OP_WIN_SEL:      cmd.win_sel  = 1'b1;
        OP_RX_OFF:       cmd.rx_off   = 1'b1;
        OP_RX_ON:        cmd.rx_on    = 1'b1;
        OP_REQ_INT:      cmd.req_int  = 1'b1;
        OP_ACK_INT:      cmd.ack_int  = 1'b1;
        OP_SET_MASK:     cmd.set_mask = 1'b1;
        OP_SET_FILTER:   cmd.set_filt = 1'b1;
        default:         ;
      endcase
    end
  end
endmodule

// File: rtl/hcc_busy_timer.sv
module hcc_busy_timer #(
  parameter int unsigned HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= CNT_W'(HOLD);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/hcc_cause_bank.sv
module hcc_cause_bank #(
  parameter int unsigned N_CAUSE = 7,
  parameter int unsigned REQ_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [N_CAUSE-1:0] evt,
  input  logic             req,
  input  logic             ack_en,
  input  logic [N_CAUSE:0] ack_bits,
  input  logic [N_CAUSE:1] mask,
  output logic [N_CAUSE:0] causes
);
  logic [N_CAUSE:1] raise;
  logic [N_CAUSE:0] ack;
  logic             latch_set;

  assign ack = ack_en ? ack_bits : '0;

  for (genvar i = 1; i <= N_CAUSE; i++) begin : g_cause
    if (i == REQ_BIT) begin : g_req
      assign raise[i] = evt[i-1] | req;
    end else begin : g_evt
      assign raise[i] = evt[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        causes[i] <= 1'b0;
      else if (clear)    causes[i] <= 1'b0;
      else if (raise[i]) causes[i] <= 1'b1;
      else if (ack[i])   causes[i] <= 1'b0;
    end
  end

  assign latch_set = |(raise & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         causes[0] <= 1'b0;
    else if (clear)     causes[0] <= 1'b0;
    else if (latch_set) causes[0] <= 1'b1;
    else if (ack[0])    causes[0] <= 1'b0;
  end
endmodule

// File: rtl/host_cmd_ctrl.sv
module host_cmd_ctrl
  import hcc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 4'hE,
  parameter int unsigned RESET_CYCLES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  output logic [WORD_W-1:0]     rdata,
  input  logic [CAUSE_N-1:0]    cause_evt,
  output logic                  irq,
  output logic [WIN_W-1:0]      win_sel,
  output logic                  rx_enable,
  output logic [FILT_W-1:0]     rx_filter
);
  localparam int unsigned PAD_W = WORD_W - WIN_W - 1 - (CAUSE_N + 1);

  hcc_cmd_t          cmd;
  logic              busy;
  logic [CAUSE_N:0]  causes;
  logic [CAUSE_N:1]  mask_q;
  logic [WORD_W-1:0] status_w;
  logic              unused_arg_lo;

  hcc_cmd_decode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .busy  (busy),
    .cmd   (cmd)
  );

  hcc_busy_timer #(.HOLD(RESET_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cmd.glb_rst),
    .busy  (busy)
  );

  hcc_cause_bank #(.N_CAUSE(CAUSE_N), .REQ_BIT(6)) u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cmd.glb_rst),
    .evt      (cause_evt),
    .req      (cmd.req_int),
    .ack_en   (cmd.ack_int),
    .ack_bits (cmd.arg),
    .mask     (mask_q),
    .causes   (causes)
  );

  assign unused_arg_lo = cmd.arg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_sel   <= '0;
      mask_q    <= '0;
      rx_enable <= 1'b0;
      rx_filter <= '0;
    end else if (cmd.glb_rst) begin
      win_sel   <= '0;
      mask_q    <= '0;
      rx_enable <= 1'b0;
      rx_filter <= '0;
    end else begin
      if (cmd.win_sel)  win_sel   <= cmd.arg[WIN_W-1:0];
      if (cmd.set_mask) mask_q    <= cmd.arg[CAUSE_N:1];
      if (cmd.rx_on)    rx_enable <= 1'b1;
      if (cmd.rx_off)   rx_enable <= 1'b0;
      if (cmd.set_filt) rx_filter <= cmd.arg[FILT_W-1:0];
    end
  end

  assign status_w = {win_sel, busy, {PAD_W{1'b0}}, causes};
  assign irq      = (|(causes[CAUSE_N:1] & mask_q)) | causes[0];
  assign rdata    = (rd_en && addr == CMD_ADDR) ? status_w : '0;
endmodule

// File: rtl/hcc_checker.sv
module hcc_checker #(
  parameter int unsigned ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 4'hE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic [6:0]        cause_evt,
  input logic              irq,
  input logic [2:0]        win_sel,
  input logic              rx_enable,
  input logic [3:0]        rx_filter,
  input logic [15:0]       status
);
  logic       hit;
  logic [4:0] op;
  assign hit = wr_en && (addr == CMD_ADDR) && !status[12];
  assign op  = wdata[15:11];

  AST_WIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && (op == 5'h01 || op == 5'h00)) |=> $stable(win_sel)); // R2
  AST_ACK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wdata == 16'h68FF && cause_evt == 7'h0) |=> status[7:0] == 8'h00); // R3
  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == 5'h0C) |=> status[6]); // R4
  AST_LATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> irq); // R5
  AST_RST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && op == 5'h00) |=> (status[12] && win_sel == 3'd0 && status[7:0] == 8'h00)); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && status[12]) |=> ($stable(win_sel) && $stable(rx_enable) && $stable(rx_filter))); // R7
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_evt[6] && !(hit && op == 5'h00)) |=> status[7]); // R8
endmodule

bind host_cmd_ctrl hcc_checker #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .cause_evt (cause_evt),
  .irq       (irq),
  .win_sel   (win_sel),
  .rx_enable (rx_enable),
  .rx_filter (rx_filter),
  .status    (status_w)
);

// File: tb/tb_host_cmd_ctrl.sv
module tb_host_cmd_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned RC         = 8;

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [15:0] d;
    logic [6:0]  ev;
    logic [15:0] st;
    logic        irq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'hE, 16'h0805, 7'h00, 16'hA000, 1'b0},  // R2 window 5
    '{1'b0, 4'hE, 16'h0000, 7'h01, 16'hA002, 1'b0},  // R5 masked cause
    '{1'b1, 4'hE, 16'h70FE, 7'h00, 16'hA002, 1'b1},  // R5 mask all
    '{1'b1, 4'hE, 16'h6802, 7'h00, 16'hA000, 1'b0},  // R3 ack bit1
    '{1'b0, 4'hE, 16'h0000, 7'h04, 16'hA009, 1'b1},  // R5 latch raise
    '{1'b1, 4'hE, 16'h6808, 7'h00, 16'hA001, 1'b1},  // R3 partial ack
    '{1'b1, 4'hE, 16'h6801, 7'h00, 16'hA000, 1'b0},  // R3 ack latch
    '{1'b1, 4'hE, 16'h67FF, 7'h00, 16'hA041, 1'b1},  // R4 R1 req, arg ignored
    '{1'b1, 4'hE, 16'h68FF, 7'h00, 16'hA000, 1'b0},  // R3 ack all
    '{1'b1, 4'h0, 16'h0803, 7'h00, 16'hA000, 1'b0},  // R11 R1 other address
    '{1'b1, 4'hE, 16'h0FFF, 7'h00, 16'hE000, 1'b0},  // R2 R1 window 7
    '{1'b1, 4'hE, 16'h7000, 7'h00, 16'hE000, 1'b0},  // R5 mask none
    '{1'b0, 4'hE, 16'h0000, 7'h40, 16'hE080, 1'b0},  // R5 masked, no latch
    '{1'b1, 4'hE, 16'h6880, 7'h40, 16'hE080, 1'b0},  // R8 collision
    '{1'b1, 4'hE, 16'h6880, 7'h00, 16'hE000, 1'b0}   // R3 clear bit7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b1;
  logic [3:0]  addr = 4'hE;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [6:0]  cause_evt = '0;
  logic        irq;
  logic [2:0]  win_sel;
  logic        rx_enable;
  logic [3:0]  rx_filter;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_cmd_ctrl #(.ADDR_W(4), .CMD_ADDR(4'hE), .RESET_CYCLES(RC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cause_evt(cause_evt), .irq(irq),
    .win_sel(win_sel), .rx_enable(rx_enable), .rx_filter(rx_filter)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; cause_evt = '0; addr = 4'hE; rd_en = 1'b1;
    #1;
  endtask

  task automatic drive(input logic w, input logic [3:0] a, input logic [15:0] d, input logic [6:0] ev);
    wr_en = w; addr = a; wdata = d; cause_evt = ev;
    tick();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    chk("R12 status", rdata, 16'h0000);
    chk("R12 irq", {15'b0, irq}, 16'h0);
    chk("R12 win", {13'b0, win_sel}, 16'h0);
    chk("R12 filter", {12'b0, rx_filter}, 16'h0);
    chk("R9 rx reset", {15'b0, rx_enable}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].wr, VECS[i].a, VECS[i].d, VECS[i].ev);
      chk($sformatf("vec%0d status", i), rdata, VECS[i].st);
      chk($sformatf("vec%0d irq", i), {15'b0, irq}, {15'b0, VECS[i].irq});
    end
    chk("R2 win_sel", {13'b0, win_sel}, 16'h7);

    // R9 receiver control, operand ignored on disable
    drive(1'b1, 4'hE, 16'h2000, 7'h0);
    chk("R9 rx on", {15'b0, rx_enable}, 16'h1);
    drive(1'b1, 4'hE, 16'h1FFF, 7'h0);
    chk("R9 R1 rx off", {15'b0, rx_enable}, 16'h0);
    drive(1'b1, 4'hE, 16'h2000, 7'h0);

    // R10 filter
    drive(1'b1, 4'hE, 16'h800A, 7'h0);
    chk("R10 filter A", {12'b0, rx_filter}, 16'hA);
    drive(1'b1, 4'hE, 16'h8005, 7'h0);
    chk("R10 filter 5", {12'b0, rx_filter}, 16'h5);

    // R11 read gating
    rd_en = 1'b0; #1;
    chk("R11 rd_en low", rdata, 16'h0000);
    rd_en = 1'b1; addr = 4'h0; #1;
    chk("R11 other addr", rdata, 16'h0000);
    addr = 4'hE; #1;

    // R6 R7 global reset with pending state
    drive(1'b1, 4'hE, 16'h70FE, 7'h00);
    drive(1'b0, 4'hE, 16'h0000, 7'h08);
    chk("R5 pending", rdata, 16'hE011);
    drive(1'b1, 4'hE, 16'h0000, 7'h00);
    for (int i = 0; i < RC; i++) begin
      chk($sformatf("R6 busy %0d", i), {15'b0, rdata[12]}, 16'h1);
      if (i == 2) drive(1'b1, 4'hE, 16'h0802, 7'h0);
      else tick();
    end
    chk("R6 busy done", rdata, 16'h0000);
    chk("R7 window ignored", {13'b0, win_sel}, 16'h0);
    chk("R6 rx cleared", {15'b0, rx_enable}, 16'h0);
    chk("R6 filter cleared", {12'b0, rx_filter}, 16'h0);
    chk("R6 irq low", {15'b0, irq}, 16'h0);
    drive(1'b0, 4'hE, 16'h0000, 7'h01);
    chk("R6 mask cleared", {15'b0, irq}, 16'h0);
    drive(1'b1, 4'hE, 16'h0802, 7'h0);
    chk("R2 after reset", rdata, 16'h4002);

    done = 1'b1;
    report();
  end
endmodule